// File: doc/BRIEF.md
# Chained Control-Block DMA Channel

This block is one DMA channel that works through a linked list of control blocks held in memory. To start it, software presents the address of the first block and pulses a start input. The channel reads the block's header words over a request/grant memory master port. It decodes the transfer-control word and moves the data one 32-bit word per beat: a read from the source followed by a write to the destination. When the block is done, the channel loads the block's link word as the next block address. A link of zero returns the channel to idle. A link that points back to an earlier block gives endless cyclic operation.

Each block occupies eight 32-bit words on a 32-byte boundary. Word 0 is the transfer-control word, word 1 the source address, word 2 the destination address, word 3 the byte length, word 4 is reserved and word 5 is the link. Words 6 and 7 are never read. The transfer-control word has these fields:

| Bit(s) | Function |
|---|---|
| 0 | interrupt on completion |
| 3 | write-response wait (accepted; writes already complete on grant) |
| 4 | destination increment |
| 6 | destination pacing |
| 7 | destination write suppress |
| 8 | source increment |
| 10 | source pacing |
| 11 | source read suppress |
| 20:16 | pacing-line select |
| 25:21 | idle cycles per beat |

The status outputs show the live block, source and destination addresses and the remaining byte count, so software can compute the remaining work at any time. The FSM has seven states:

| State | Role | Leaves to |
|---|---|---|
| IDLE | waiting | FETCH on a start pulse |
| FETCH | six header reads | DECODE after word 5 |
| DECODE | inspect the header | FINISH on zero length; PAUSE when a wait count is set; READ otherwise |
| PAUSE | wait cycles | READ when the count runs out |
| READ | source beat | WRITE when data is taken or the read is suppressed |
| WRITE | destination beat | FINISH on the last beat; PAUSE or READ otherwise |
| FINISH | block end | IDLE on a zero link; FETCH otherwise |

Top module: `dmaseq_top`

## Requirements
- R1: After reset the channel is idle, issues no memory request, shows a block address of zero and has the END, INT and irq outputs low.
- R2: A start pulse while idle fetches header words 0 to 5 from the start address with its low five bits cleared. A start pulse while the channel is active is ignored and the block address does not change.
- R3: Each beat reads one word at the source address and writes it to the destination address. The source advances by 4 after each beat when bit 8 is set, and the destination advances by 4 when bit 4 is set. A pointer whose increment bit is clear stays fixed.
- R4: With bit 11 set, no source read is issued and the value zero is written. With bit 7 set, no destination write is issued, yet the addresses still advance.
- R5: At block end the link word (word 5, low five bits cleared) becomes the block address. A zero link leaves the channel idle with the block address reading zero.
- R6: With bit 10 (or bit 6) set, a source (or destination) beat is requested only while the pacing line selected by bits 20:16 is high. The channel holds its position while that line is low.
- R7: Bits 25:21 give W idle cycles ahead of every beat, so a block of N beats takes exactly N*W cycles more than the same block with W = 0.
- R8: Completion of a block with bit 0 set raises END, INT and irq. These stay high until a clear pulse. A block with bit 0 clear does not raise them.
- R9: A block with length zero moves no data and goes straight on to its link.
- R10: When the reduced-channel parameter is set, a block length larger than 65532 bytes is cut to 65532 bytes.
- R11: A link that points back to an earlier block repeats the chain endlessly and raises the interrupt on every pass through the flagged block.
- R12: The source, destination and remaining-length outputs show the live transfer position between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Start pulse; taken only while idle |
| sw_cb_addr | input | 32 | Address of the first control block |
| sw_int_clr | input | 1 | Clears the END and INT flags |
| dreq | input | NUM_DREQ | Peripheral pacing lines |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; the access completes in the cycle it is granted |
| mem_rdata | input | 32 | Read data, valid with the grant |
| st_active | output | 1 | Channel not idle |
| st_end | output | 1 | A flagged block has ended |
| st_int | output | 1 | Interrupt status flag |
| irq | output | 1 | Interrupt output |
| st_cb_addr | output | 32 | Current control-block address |
| st_src | output | 32 | Current source address |
| st_dst | output | 32 | Current destination address |
| st_remain | output | 32 | Bytes left in the current block |

## Verification
The copy path is exercised with four kinds of block: both pointers incrementing, a fixed source feeding an incrementing destination, a suppressed source, and a suppressed destination. Together these separate the increment bits from the suppress bits. Pacing is held low on the source side and on the destination side, and is released one beat at a time so that the mid-transfer position can be read. This shows that gating applies to the right side and to the right line. Block timing is compared with and without wait cycles, and chains are run with a zero-length block, a block over the length cap and a loop. These show the link handling, the interrupt sites and the cap apart from ordinary termination.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_PAUSE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } seq_state_t;

    // transfer-control word field positions
    localparam int TC_IRQ_EN  = 0;
    localparam int TC_WRESP   = 3;
    localparam int TC_D_INC   = 4;
    localparam int TC_D_PACE  = 6;
    localparam int TC_D_SKIP  = 7;
    localparam int TC_S_INC   = 8;
    localparam int TC_S_PACE  = 10;
    localparam int TC_S_SKIP  = 11;
    localparam int TC_SEL_LO  = 16;
    localparam int TC_WAIT_LO = 21;
    localparam int FIELD_W    = 5;

    // header word indices
    localparam logic [2:0] HW_CTRL = 3'd0;
    localparam logic [2:0] HW_SRC  = 3'd1;
    localparam logic [2:0] HW_DST  = 3'd2;
    localparam logic [2:0] HW_LEN  = 3'd3;
    localparam logic [2:0] HW_LINK = 3'd5;

endpackage

// File: rtl/dmaseq_wait_timer.sv
module dmaseq_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // the last counted cycle is the one holding value 1
    assign expired = (cnt <= CNT_W'(1));

endmodule

// File: rtl/dmaseq_pace_gate.sv
module dmaseq_pace_gate #(
    parameter int NUM_DREQ = 32,
    parameter int SEL_W    = 5
) (
    input  logic [NUM_DREQ-1:0] dreq,
    input  logic [SEL_W-1:0]    sel,
    input  logic                src_pace,
    input  logic                dst_pace,
    output logic                rd_go,
    output logic                wr_go
);
    localparam int LINES = 1 << SEL_W;

    logic [LINES-1:0] lines;
    logic             line_hi;

    generate
        if (NUM_DREQ >= LINES) begin : g_trim
            assign lines = dreq[LINES-1:0];
        end else begin : g_pad
            assign lines = {{(LINES-NUM_DREQ){1'b0}}, dreq};
        end
    endgenerate

    assign line_hi = lines[sel];
    assign rd_go   = !src_pace || line_hi;
    assign wr_go   = !dst_pace || line_hi;

endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int NUM_DREQ  = 32,
    parameter bit LITE_CHAN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_start,
    input  logic [31:0]         sw_cb_addr,
    input  logic                sw_int_clr,
    input  logic [NUM_DREQ-1:0] dreq,
    output logic                mem_req,
    output logic                mem_we,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_gnt,
    input  logic [31:0]         mem_rdata,
    output logic                st_active,
    output logic                st_end,
    output logic                st_int,
    output logic                irq,
    output logic [31:0]         st_cb_addr,
    output logic [31:0]         st_src,
    output logic [31:0]         st_dst,
    output logic [31:0]         st_remain
);
    localparam logic [31:0] LEN_CAP   = LITE_CHAN ? 32'd65532 : 32'h4000_0000;
    localparam logic [31:0] BEAT_B    = 32'd4;
    localparam logic [31:0] ALIGN_MSK = 32'hFFFF_FFE0;

    seq_state_t state, state_nx;

    logic [2:0]  widx;
    logic [31:0] cb_addr, ctrl, src, dst, remain, link, beat_data;
    logic        end_f, int_f;

    logic [FIELD_W-1:0] wait_n, sel;
    logic rd_go, wr_go, t_expired, t_load;
    logic s_skip, d_skip, last_beat, beat_done, read_done;

    assign wait_n    = ctrl[TC_WAIT_LO +: FIELD_W];
    assign sel       = ctrl[TC_SEL_LO +: FIELD_W];
    assign s_skip    = ctrl[TC_S_SKIP];
    assign d_skip    = ctrl[TC_D_SKIP];
    assign last_beat = (remain <= BEAT_B);
    assign read_done = s_skip || (rd_go && mem_gnt);
    assign beat_done = d_skip || (wr_go && mem_gnt);

    dmaseq_pace_gate #(.NUM_DREQ(NUM_DREQ), .SEL_W(FIELD_W)) u_gate (
        .dreq     (dreq),
        .sel      (sel),
        .src_pace (ctrl[TC_S_PACE]),
        .dst_pace (ctrl[TC_D_PACE]),
        .rd_go    (rd_go),
        .wr_go    (wr_go)
    );

    assign t_load = (state_nx == ST_PAUSE) && (state != ST_PAUSE);

    dmaseq_wait_timer #(.CNT_W(FIELD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (wait_n),
        .expired  (t_expired)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sw_start) state_nx = ST_FETCH;
            ST_FETCH:  if (mem_gnt && widx == HW_LINK) state_nx = ST_DECODE;
            ST_DECODE: begin
                if (remain == '0)        state_nx = ST_FINISH;
                else if (wait_n != '0)   state_nx = ST_PAUSE;
                else                     state_nx = ST_READ;
            end
            ST_PAUSE:  if (t_expired) state_nx = ST_READ;
            ST_READ:   if (read_done) state_nx = ST_WRITE;
            ST_WRITE: begin
                if (beat_done) begin
                    if (last_beat)           state_nx = ST_FINISH;
                    else if (wait_n != '0)   state_nx = ST_PAUSE;
                    else                     state_nx = ST_READ;
                end
            end
            ST_FINISH: state_nx = ((link & ALIGN_MSK) == '0) ? ST_IDLE : ST_FETCH;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx      <= '0;
            cb_addr   <= '0;
            ctrl      <= '0;
            src       <= '0;
            dst       <= '0;
            remain    <= '0;
            link      <= '0;
            beat_data <= '0;
            end_f     <= 1'b0;
            int_f     <= 1'b0;
        end else begin
            if (sw_int_clr) begin
                end_f <= 1'b0;
                int_f <= 1'b0;
            end
            unique case (state)
                ST_IDLE: if (sw_start) begin
                    cb_addr <= sw_cb_addr & ALIGN_MSK;
                    widx    <= '0;
                end
                ST_FETCH: if (mem_gnt) begin
                    unique case (widx)
                        HW_CTRL: ctrl   <= mem_rdata;
                        HW_SRC:  src    <= mem_rdata;
                        HW_DST:  dst    <= mem_rdata;
                        HW_LEN:  remain <= (mem_rdata > LEN_CAP) ? LEN_CAP : mem_rdata;
                        HW_LINK: link   <= mem_rdata;
                        default: ;
                    endcase
                    widx <= widx + 3'd1;
                end
                ST_READ: begin
                    if (s_skip)       beat_data <= '0;
                    else if (rd_go && mem_gnt) beat_data <= mem_rdata;
                end
                ST_WRITE: if (beat_done) begin
                    if (ctrl[TC_S_INC]) src <= src + BEAT_B;
                    if (ctrl[TC_D_INC]) dst <= dst + BEAT_B;
                    remain <= last_beat ? '0 : remain - BEAT_B;
                end
                ST_FINISH: begin
                    cb_addr <= link & ALIGN_MSK;
                    widx    <= '0;
                    if (ctrl[TC_IRQ_EN]) begin
                        end_f <= 1'b1;
                        int_f <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = beat_data;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cb_addr + {27'd0, widx, 2'b00};
            end
            ST_READ: begin
                mem_req  = !s_skip && rd_go;
                mem_addr = src;
            end
            ST_WRITE: begin
                mem_req  = !d_skip && wr_go;
                mem_we   = 1'b1;
                mem_addr = dst;
            end
            default: ;
        endcase
    end

    assign st_active  = (state != ST_IDLE);
    assign st_end     = end_f;
    assign st_int     = int_f;
    assign irq        = int_f;
    assign st_cb_addr = cb_addr;
    assign st_src     = src;
    assign st_dst     = dst;
    assign st_remain  = remain;

    // assertions
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_active |-> !mem_req); // R1

    AST_FETCH_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && state == ST_FETCH) |-> (mem_addr[1:0] == 2'b00 && mem_addr[4:2] <= 3'd5)); // R2

    AST_CB_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && state != ST_FINISH) |=> (cb_addr == $past(cb_addr))); // R2

    AST_NO_WRITE_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !ctrl[TC_D_SKIP]); // R4

    AST_IDLE_CB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (st_cb_addr == '0)); // R5

    AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_int && !sw_int_clr) |=> st_int); // R8

endmodule

// File: tb/tb_dmaseq_top.sv
module tb_dmaseq_top;
    localparam int ND = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start = 1'b0, sw_int_clr = 1'b0;
    logic [31:0] sw_cb_addr = '0;
    logic [ND-1:0] dreq = '0;
    logic mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic st_active, st_end, st_int, irq;
    logic [31:0] st_cb_addr, st_src, st_dst, st_remain;

    logic [31:0] mem [4096];
    logic tb_we = 1'b0;
    logic [31:0] tb_a = '0, tb_d = '0;
    int wr_cnt = 0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    dmaseq_top #(.NUM_DREQ(ND), .LITE_CHAN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_cb_addr(sw_cb_addr),
        .sw_int_clr(sw_int_clr), .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .st_active(st_active), .st_end(st_end),
        .st_int(st_int), .irq(irq), .st_cb_addr(st_cb_addr), .st_src(st_src),
        .st_dst(st_dst), .st_remain(st_remain)
    );

    assign mem_gnt   = mem_req;
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (tb_we) mem[tb_a[13:2]] <= tb_d;
        else if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic put_cb(input logic [31:0] b, input logic [31:0] ctl, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] len, input logic [31:0] nx);
        poke(b, ctl); poke(b + 4, s); poke(b + 8, d); poke(b + 12, len); poke(b + 20, nx);
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk); sw_start = 1'b1; sw_cb_addr = a;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (st_active && cyc < 40000) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic clr_int();
        @(negedge clk); sw_int_clr = 1'b1;
        @(negedge clk); sw_int_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 active", {31'd0, st_active}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 cb", st_cb_addr, 32'd0);
        chk("R1 flags", {29'd0, st_end, st_int, irq}, 32'd0);
    endtask

    task automatic t_copy();
        int c;
        for (int i = 0; i < 4; i++) poke(32'h400 + 4 * i, 32'hA000_0000 + i);
        put_cb(32'h100, 32'h0000_0110, 32'h400, 32'h800, 32'd16, 32'h0);
        kick(32'h10C);  // low bits dropped: R2
        wait_idle(c);
        for (int i = 0; i < 4; i++) chk("R3 R2 copy data", mem[(32'h800 >> 2) + i], 32'hA000_0000 + i);
        chk("R3 src end", st_src, 32'h410);
        chk("R3 dst end", st_dst, 32'h810);
        chk("R5 cb zero", st_cb_addr, 32'h0);
        chk("R8 no int", {31'd0, st_int}, 32'd0);
    endtask

    task automatic t_chain();
        int c;
        poke(32'h500, 32'h5555_1234);
        // fixed source, incrementing dest, 3 beats, link to second block
        put_cb(32'h120, 32'h0000_0010, 32'h500, 32'hB00, 32'd12, 32'h140);
        // suppressed source, incrementing dest, interrupt
        put_cb(32'h140, 32'h0000_0811, 32'h500, 32'hB0C, 32'd8, 32'h0);
        poke(32'hB0C, 32'hFFFF_FFFF); poke(32'hB10, 32'hFFFF_FFFF);
        kick(32'h120);
        wait_idle(c);
        for (int i = 0; i < 3; i++) chk("R3 fixed src", mem[(32'hB00 >> 2) + i], 32'h5555_1234);
        chk("R4 zero data a", mem[32'hB0C >> 2], 32'h0);
        chk("R4 zero data b", mem[32'hB10 >> 2], 32'h0);
        chk("R5 chained end dst", st_dst, 32'hB14);
        chk("R8 int set", {29'd0, st_end, st_int, irq}, 32'h7);
        clr_int();
        chk("R8 int cleared", {29'd0, st_end, st_int, irq}, 32'h0);
    endtask

    task automatic t_dskip();
        int c, w0;
        w0 = wr_cnt;
        put_cb(32'h160, 32'h0000_0190, 32'h400, 32'hC00, 32'd16, 32'h0);
        kick(32'h160);
        wait_idle(c);
        chk("R4 no writes", wr_cnt - w0, 32'd0);
        chk("R4 src advanced", st_src, 32'h410);
        chk("R4 dst advanced", st_dst, 32'hC10);
    endtask

    task automatic t_zero_len();
        int c, w0;
        w0 = wr_cnt;
        put_cb(32'h180, 32'h0000_0001, 32'h400, 32'hD00, 32'd0, 32'h1A0);
        put_cb(32'h1A0, 32'h0000_0110, 32'h404, 32'hA00, 32'd4, 32'h0);
        kick(32'h180);
        wait_idle(c);
        chk("R9 one write only", wr_cnt - w0, 32'd1);
        chk("R9 next block data", mem[32'hA00 >> 2], 32'hA000_0001);
        chk("R9 R8 int from empty block", {31'd0, st_int}, 32'd1);
        clr_int();
    endtask

    task automatic t_pace();
        int c, w0;
        w0 = wr_cnt;
        dreq = '0;
        // dest paced on line 5
        put_cb(32'h1C0, 32'h0005_0150, 32'h400, 32'h900, 32'd12, 32'h0);
        kick(32'h1C0);
        repeat (30) @(negedge clk);
        chk("R6 dst held", st_dst, 32'h900);
        chk("R6 no write while low", wr_cnt - w0, 32'd0);
        kick(32'h200);
        chk("R2 start ignored busy", st_cb_addr, 32'h1C0);
        dreq[5] = 1'b1;
        @(negedge clk); dreq[5] = 1'b0;
        @(negedge clk);
        chk("R12 live dst", st_dst, 32'h904);
        chk("R12 live src", st_src, 32'h404);
        chk("R12 live remain", st_remain, 32'd8);
        dreq[5] = 1'b1;
        wait_idle(c);
        dreq = '0;
        chk("R6 paced data", mem[(32'h900 >> 2) + 2], 32'hA000_0002);
        // source paced on line 9
        put_cb(32'h1E0, 32'h0009_0510, 32'h400, 32'hE00, 32'd8, 32'h0);
        kick(32'h1E0);
        repeat (25) @(negedge clk);
        chk("R6 src held", st_src, 32'h400);
        chk("R6 src active", {31'd0, st_active}, 32'd1);
        dreq[9] = 1'b1;
        wait_idle(c);
        dreq = '0;
        chk("R6 src paced data", mem[(32'hE00 >> 2) + 1], 32'hA000_0001);
    endtask

    task automatic t_wait();
        int c0, c3;
        put_cb(32'h220, 32'h0000_0110, 32'h400, 32'hF00, 32'd12, 32'h0);
        kick(32'h220); wait_idle(c0);
        put_cb(32'h220, 32'h0060_0110, 32'h400, 32'hF00, 32'd12, 32'h0);
        kick(32'h220); wait_idle(c3);
        chk("R7 wait cycles", c3 - c0, 32'd9);
    endtask

    task automatic t_lite();
        int c;
        put_cb(32'h240, 32'h0000_0890, 32'h0, 32'h1_0000, 32'd70000, 32'h0);
        kick(32'h240); wait_idle(c);
        chk("R10 capped dst", st_dst, 32'h1_0000 + 32'd65532);
        chk("R10 remain zero", st_remain, 32'd0);
    endtask

    task automatic t_cyclic();
        int n;
        poke(32'h600, 32'h1111_0001); poke(32'h604, 32'h2222_0002);
        put_cb(32'h300, 32'h0000_0000, 32'h600, 32'h700, 32'd4, 32'h320);
        put_cb(32'h320, 32'h0000_0001, 32'h604, 32'h704, 32'd4, 32'h300);
        kick(32'h300);
        for (int k = 0; k < 3; k++) begin
            n = 0;
            while (!irq && n < 500) begin @(negedge clk); n++; end
            chk("R11 irq each pass", {31'd0, irq}, 32'd1);
            chk("R11 still running", {31'd0, st_active}, 32'd1);
            clr_int();
            n = 0;
            while (st_cb_addr != 32'h320 && n < 500) begin @(negedge clk); n++; end
            chk("R8 plain block no int", {31'd0, st_int}, 32'd0);
        end
        chk("R11 loop data", mem[32'h704 >> 2], 32'h2222_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy();
        t_chain();
        t_dskip();
        t_zero_len();
        t_pace();
        t_wait();
        t_lite();
        t_cyclic();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule